// File: doc/BRIEF.md
# ADC Result Holding and Trigger Selection Registers

This block connects a converter engine to an 8-bit peripheral bus. Each time the engine finishes a conversion, it signals a one-cycle done strobe and a 10-bit sample. The block stores that sample and shows it to the bus as two read-only bytes. A justification input sets the byte layout. Right-justified layout suits full 10-bit reads. Left-justified layout puts the eight most significant bits in the high byte, so software that needs only 8 bits can read that byte alone.

Software that wants the full 10-bit result reads the low byte first and then the high byte. Reading the low byte locks the stored sample. Any conversion that completes during the lock is discarded, so the two bytes always come from the same sample. Reading the high byte releases the lock.

The block also holds a byte-wide control register. It selects one of eight interrupt-flag inputs as the auto-trigger source. When auto-trigger is enabled, the block sends a single-cycle conversion start pulse on each rising edge of the selected flag. The edge detector watches the output of the selection multiplexer. As a result, switching the selection from a low flag to a high flag also counts as an edge.

Top module: `adc_result_regs`

## Requirements
- R1: After reset, the stored sample is 0, the control register is 0, every bus address reads 0 and `conv_start` is low.
- R2: With `justify_left` = 0, address 1 (high byte) reads {6'b0, sample[9:8]} and address 0 (low byte) reads sample[7:0].
- R3: With `justify_left` = 1, address 1 reads sample[9:2] and address 0 reads {sample[1:0], 6'b0}.
- R4: When no lock is held and no low-byte read is in progress, a `conv_done` strobe stores `conv_data`, which becomes readable after the next clock edge.
- R5: A read strobe on address 0 sets a lock. While the lock is held, and also in the same cycle as the low-byte read, any completing conversion is dropped and both bytes keep their values.
- R6: A read strobe on address 1 with no lock held creates no lock, so the next conversion is stored normally.
- R7: A read strobe on address 1 releases the lock, and the next completed conversion after that is stored.
- R8: Address 2 is the control register. Bits 2:0 hold the trigger source index and bit 6 is a plain storage bit. Bits 7 and 5:3 always read 0. Writes use `bus_wr`. Address 3 reads 0.
- R9: While `auto_trig_en` is 0, `conv_start` stays low regardless of flag activity.
- R10: With `auto_trig_en` = 1, a rising edge on the flag selected by bits 2:0 raises `conv_start` for exactly one cycle, starting one cycle after the clock edge that samples the high flag.
- R11: Rewriting the source index from a flag that is low to a flag that is already high produces one `conv_start` pulse, one cycle after the write takes effect.
- R12: Edges on flags that are not selected never produce `conv_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control |
| bus_rd | input | 1 | Read strobe; drives lock set and release |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| justify_left | input | 1 | Result layout select, 1 = left-justified |
| auto_trig_en | input | 1 | Auto-trigger enable |
| conv_done | input | 1 | Conversion complete strobe |
| conv_data | input | 10 | Conversion sample |
| irq_flags | input | 8 | Candidate trigger flags |
| conv_start | output | 1 | Single-cycle conversion start request |

## Verification
The hardest case to reach is a conversion that completes while the pair is locked, and especially one that completes in the same cycle as the low-byte read. The bench sets up this case by issuing the read strobe and the done strobe on the same clock edge. It then issues another done strobe before any high-byte read and checks that the first sample survives both attempts. The source-switch edge is reached by holding a flag high, selecting a low flag, and then rewriting the index while the flags stay still. The bench also sweeps every sample value in both layouts and every source and flag pairing.

// File: rtl/adc_result_pkg.sv
// Package: shared widths, bus address map and control-register bit positions
// for the ADC result register block. Assumes a result wider than a bus byte
// but no wider than two bytes.
package adc_result_pkg;
    localparam int RES_W    = 10;
    localparam int BYTE_W   = 8;
    localparam int N_SRC    = 8;
    localparam int SRC_W    = $clog2(N_SRC);
    localparam int ADDR_W   = 2;
    localparam int SPARE_BIT = 6;

    typedef enum logic [ADDR_W-1:0] {
        A_LO   = 2'd0,
        A_HI   = 2'd1,
        A_CTRL = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             spare;
        logic [SRC_W-1:0] src;
    } ctrl_t;
endpackage

// File: rtl/adc_res_store.sv
// Module: adc_res_store
// Holds the latest conversion sample and the read-consistency lock.
// A low-byte read sets the lock, and a high-byte read clears it.
// A done strobe is stored only when no lock is held and no low-byte read
// is in progress. Assumes the read strobes are single-cycle qualified.
module adc_res_store #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_lo,
    input  logic             rd_hi,
    input  logic             done,
    input  logic [RES_W-1:0] data,
    output logic [RES_W-1:0] sample,
    output logic             locked
);
    logic             lock_q;
    logic [RES_W-1:0] sample_q;
    logic             capture;

    // Decide whether this cycle's completed conversion may be stored.
    always_comb begin
        capture = done && !lock_q && !rd_lo;
    end

    // Track the lock across a low-byte then high-byte read pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (rd_hi) begin
            lock_q <= 1'b0;
        end else if (rd_lo) begin
            lock_q <= 1'b1;
        end
    end

    // Store the sample when capture is allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
        end else if (capture) begin
            sample_q <= data;
        end
    end

    assign sample = sample_q;
    assign locked = lock_q;
endmodule

// File: rtl/adc_res_format.sv
// Module: adc_res_format
// Splits the stored sample into a high byte and a low byte, either right
// or left justified. Purely combinational. Assumes BYTE_W < RES_W <= 2*BYTE_W.
module adc_res_format #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              left,
    input  logic [RES_W-1:0]  sample,
    output logic [BYTE_W-1:0] hi_byte,
    output logic [BYTE_W-1:0] lo_byte
);
    localparam int PAIR_W = 2 * BYTE_W;
    localparam int PAD_W  = PAIR_W - RES_W;

    logic [PAIR_W-1:0] right_pair;
    logic [PAIR_W-1:0] left_pair;
    logic [PAIR_W-1:0] pair;

    generate
        if (PAD_W > 0) begin : g_pad
            assign right_pair = {{PAD_W{1'b0}}, sample};
            assign left_pair  = {sample, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign right_pair = sample;
            assign left_pair  = sample;
        end
    endgenerate

    // Pick the layout and split it into bytes.
    always_comb begin
        pair    = left ? left_pair : right_pair;
        hi_byte = pair[PAIR_W-1:BYTE_W];
        lo_byte = pair[BYTE_W-1:0];
    end
endmodule

// File: rtl/adc_trig_ctrl.sv
// Module: adc_trig_ctrl
// Holds the trigger-select control register, which contains the source
// index and a spare storage bit. Also registers the multiplexed flag and
// produces a registered single-cycle start on its rising edge when
// auto-trigger is enabled. Because the edge is taken after the mux, a
// source change onto a high flag also fires a start.
module adc_trig_ctrl #(
    parameter int N_SRC     = 8,
    parameter int BYTE_W    = 8,
    parameter int SPARE_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              auto_en,
    input  logic [N_SRC-1:0]  flags,
    output logic [BYTE_W-1:0] ctrl_rdata,
    output logic              start
);
    localparam int SRC_W = $clog2(N_SRC);

    logic [SRC_W-1:0] src_q;
    logic             spare_q;
    logic             sel;
    logic             sel_q;
    logic             start_q;

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            spare_q <= 1'b0;
        end else if (wr_ctrl) begin
            src_q   <= wdata[SRC_W-1:0];
            spare_q <= wdata[SPARE_BIT];
        end
    end

    // Select the active flag and assemble the register read value.
    always_comb begin
        sel                   = flags[src_q];
        ctrl_rdata            = '0;
        ctrl_rdata[SRC_W-1:0] = src_q;
        ctrl_rdata[SPARE_BIT] = spare_q;
    end

    // Remember the previous mux output and emit a pulse on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            start_q <= 1'b0;
        end else begin
            sel_q   <= sel;
            start_q <= auto_en && sel && !sel_q;
        end
    end

    assign start = start_q;
endmodule

// File: rtl/adc_result_regs.sv
// Module: adc_result_regs (top)
// Bus-facing ADC result and trigger-select register block. Decodes the
// address, steers reads to the result bytes or the control register, and
// connects the storage, formatting and trigger submodules. Read data is
// combinational, and read strobes take effect at the next edge.
module adc_result_regs
    import adc_result_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              justify_left,
    input  logic              auto_trig_en,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    input  logic [N_SRC-1:0]  irq_flags,
    output logic              conv_start
);
    logic              rd_lo, rd_hi, wr_ctrl;
    logic [RES_W-1:0]  sample;
    logic              locked;
    logic [BYTE_W-1:0] hi_byte, lo_byte, ctrl_rdata;

    // Decode bus strobes per register.
    always_comb begin
        rd_lo   = bus_rd && (bus_addr == A_LO);
        rd_hi   = bus_rd && (bus_addr == A_HI);
        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    end

    adc_res_store #(.RES_W(RES_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_lo  (rd_lo),
        .rd_hi  (rd_hi),
        .done   (conv_done),
        .data   (conv_data),
        .sample (sample),
        .locked (locked)
    );

    adc_res_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
        .left    (justify_left),
        .sample  (sample),
        .hi_byte (hi_byte),
        .lo_byte (lo_byte)
    );

    adc_trig_ctrl #(.N_SRC(N_SRC), .BYTE_W(BYTE_W), .SPARE_BIT(SPARE_BIT)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wdata      (bus_wdata),
        .auto_en    (auto_trig_en),
        .flags      (irq_flags),
        .ctrl_rdata (ctrl_rdata),
        .start      (conv_start)
    );

    // Read-data multiplexer.
    always_comb begin
        unique case (bus_addr)
            A_LO:    bus_rdata = lo_byte;
            A_HI:    bus_rdata = hi_byte;
            A_CTRL:  bus_rdata = ctrl_rdata;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/adc_result_regs_chk.sv
// Module: adc_result_regs_chk
// Assertion checker bound into adc_result_regs. It watches the bus, the
// stored sample, the lock and the start output.
module adc_result_regs_chk
    import adc_result_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              auto_trig_en,
    input logic              conv_done,
    input logic [RES_W-1:0]  conv_data,
    input logic              conv_start,
    input logic [RES_W-1:0]  sample,
    input logic              locked
);
    // R5: a low-byte read without a high-byte read leaves the lock set.
    assert_lock_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_LO) |=> locked);

    // R5: the sample stays frozen while locked.
    assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(sample));

    // R4: an unlocked done strobe stores its data.
    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !locked && !(bus_rd && bus_addr == A_LO))
            |=> sample == $past(conv_data));

    // R7: a high-byte read releases the lock.
    assert_unlock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_HI) |=> !locked);

    // R10: the start pulse lasts one cycle.
    assert_start_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R9: no start when auto-trigger was off.
    assert_no_start_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_trig_en |=> !conv_start);

    // R8: reserved control bits read as zero.
    assert_ctrl_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> (bus_rdata[7] == 1'b0 && bus_rdata[5:3] == 3'b0));
endmodule

bind adc_result_regs adc_result_regs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .auto_trig_en (auto_trig_en),
    .conv_done    (conv_done),
    .conv_data    (conv_data),
    .conv_start   (conv_start),
    .sample       (sample),
    .locked       (locked)
);

// File: tb/adc_result_regs_tb.sv
module adc_result_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       justify_left = 1'b0, auto_trig_en = 1'b0, conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic [7:0] irq_flags = '0;
    logic       conv_start;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    adc_result_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .justify_left(justify_left), .auto_trig_en(auto_trig_en),
        .conv_done(conv_done), .conv_data(conv_data), .irq_flags(irq_flags),
        .conv_start(conv_start)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_at(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic conv(input logic [9:0] v);
        conv_done = 1'b1; conv_data = v;
        tick();
        conv_done = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        bus_addr = 2'd2; bus_wr = 1'b1; bus_wdata = v;
        tick();
        bus_wr = 1'b0;
    endtask

    function automatic int exp_hi(input logic [9:0] s, input logic l);
        return l ? int'(s >> 2) : int'(s >> 8);
    endfunction

    function automatic int exp_lo(input logic [9:0] s, input logic l);
        return l ? int'((s % 4) * 64) : int'(s % 256);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        logic [7:0] hi_save, lo_save;
        repeat (3) tick();
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd_at(2'(a), v);
            chk("R1 reset read", int'(v), 0);
        end
        chk("R1 reset start", int'(conv_start), 0);
        rst_n = 1'b1;
        tick();

        // R2 R3 R4: every sample value in both layouts
        for (int s = 0; s < 1024; s++) begin
            conv(10'(s));
            for (int l = 0; l < 2; l++) begin
                justify_left = l[0];
                rd_at(2'd1, v); chk(l ? "R3 hi" : "R2 hi", int'(v), exp_hi(10'(s), l[0]));
                rd_at(2'd0, v); chk(l ? "R3 lo" : "R2 lo", int'(v), exp_lo(10'(s), l[0]));
            end
        end
        justify_left = 1'b0;

        // R5: lock on low read; same-cycle and later done strobes dropped
        conv(10'h2A5);
        bus_addr = 2'd0; bus_rd = 1'b1; conv_done = 1'b1; conv_data = 10'h111;
        tick();
        bus_rd = 1'b0; conv_done = 1'b0;
        rd_at(2'd0, v); chk("R5 same-cycle drop lo", int'(v), 'hA5);
        conv(10'h0F0);
        rd_at(2'd1, v); chk("R5 locked hi", int'(v), 2);
        rd_at(2'd0, v); chk("R5 locked lo", int'(v), 'hA5);
        // R7: high read releases, next done stores
        bus_addr = 2'd1; bus_rd = 1'b1;
        tick();
        bus_rd = 1'b0;
        rd_at(2'd0, v); chk("R7 after release unchanged", int'(v), 'hA5);
        conv(10'h35A);
        rd_at(2'd1, v); chk("R7 hi new", int'(v), 3);
        rd_at(2'd0, v); chk("R7 lo new", int'(v), 'h5A);

        // R6: high-only read makes no lock
        justify_left = 1'b1;
        bus_addr = 2'd1; bus_rd = 1'b1;
        tick();
        bus_rd = 1'b0;
        conv(10'h3FC);
        rd_at(2'd1, v); chk("R6 hi-only no lock", int'(v), 'hFF);
        justify_left = 1'b0;

        // R8: control register bits and address 3
        wr_ctrl(8'hFF);
        rd_at(2'd2, v); chk("R8 ctrl ff", int'(v), 'h47);
        wr_ctrl(8'h3D);
        rd_at(2'd2, v); chk("R8 ctrl 3d", int'(v), 'h05);
        rd_at(2'd3, v); chk("R8 addr3", int'(v), 0);

        // R10 R12: sweep source vs flag
        auto_trig_en = 1'b1;
        for (int s = 0; s < 8; s++) begin
            wr_ctrl(8'(s));
            irq_flags = '0; tick(); tick();
            for (int f = 0; f < 8; f++) begin
                irq_flags = 8'(1 << f);
                tick();
                chk(f == s ? "R10 edge start" : "R12 other flag", int'(conv_start), int'(f == s));
                tick();
                chk("R10 single pulse", int'(conv_start), 0);
                irq_flags = '0;
                tick(); tick();
            end
        end

        // R11: switch from low flag to already-high flag
        wr_ctrl(8'd0);
        irq_flags = 8'h04;
        tick(); tick();
        chk("R11 before switch", int'(conv_start), 0);
        wr_ctrl(8'd2);
        chk("R11 write cycle", int'(conv_start), 0);
        tick();
        chk("R11 switch start", int'(conv_start), 1);
        tick();
        chk("R11 single pulse", int'(conv_start), 0);

        // R9: auto off suppresses edge and switch
        auto_trig_en = 1'b0;
        wr_ctrl(8'd0);
        tick();
        wr_ctrl(8'd2);
        tick();
        chk("R9 switch off", int'(conv_start), 0);
        irq_flags = 8'h00; tick();
        irq_flags = 8'h04; tick();
        chk("R9 edge off", int'(conv_start), 0);
        tick();
        chk("R9 edge off late", int'(conv_start), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule